// File: doc/BRIEF.md
# Memory Slot Scheduler with Refresh and DMA Write Queue

This block decides, slot by slot, what a video controller's external memory port does while a host-to-memory DMA is running. A line timing generator outside the block presents one access slot per enabled clock, together with the slot's index within the line, the display-enable state and the wide/narrow line mode. The scheduler reserves refresh slots at fixed positions. Those positions depend on both the mode and whether the display is blanked. In the remaining slots it issues source-read requests to the host side and write grants toward the destination memory.

Words read from the host enter a four-entry write queue. A word cannot leave the queue until three slots after it entered. A word bound for the byte-wide main RAM drains over two write slots, high byte first. A word bound for the word-wide colour or scroll RAM drains in one slot. A refresh slot blocks both a write and a read, and it also blocks the read in the slot that follows it. The host bus stays held while the programmed transfer length is non-zero. The length counts down once per source read.

Top module: `slot_sched`

## Requirements
- R1: With wide mode and the display off, refresh_stb is high exactly in slots 37, 69, 102, 133, 165 and 197, six per line.
- R2: In narrow mode, refresh falls in slots 37, 69, 101, 133 and 165 with the display off (five), and in slots 26, 58, 90 and 122 with the display on (four).
- R3: With wide mode and the display on, refresh falls in slots 26, 58, 90, 122 and 154.
- R4: In a refresh slot neither src_rd nor mem_wr is asserted. In the next enabled slot src_rd is not asserted, but mem_wr may be.
- R5: While bus_held is high, src_rd is asserted in every enabled slot that is not blocked by R4 and in which fewer than 4 words are queued. The word on src_data is captured in that slot.
- R6: For a word-wide destination (dst_word=1 at start), each queued word drains in one mem_wr slot with wr_hi=0. A long transfer started idle at slot 0 of a 210-slot wide, display-off line makes exactly 198 source reads in that line (163 in a 171-slot narrow display-on line).
- R7: For a byte-wide destination (dst_word=0 at start), each word takes two mem_wr slots: first wr_hi=1, then wr_hi=0, both carrying the full word on wr_data. In a steady-state wide display-off line there are exactly 204 such writes.
- R8: A word read in slot t is written no earlier than slot t+3. With an empty queue a single word is written exactly in slot t+3.
- R9: At most 4 words are read but not yet fully written, and words are written in read order.
- R10: dma_start loads dma_len and samples dst_word only while bus_held is low. Each src_rd decrements the length, and bus_held is high exactly while the length is non-zero. A start with length 0, or a start while bus_held is high, has no effect.
- R11: After reset, and in any cycle with slot_en low, refresh_stb, src_rd and mem_wr are low and bus_held is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | This cycle is one access slot |
| slot_idx | input | 8 | Index of the slot within the line |
| disp_on | input | 1 | Display enabled (1) or blanked (0) |
| wide_mode | input | 1 | Wide line mode (1) or narrow (0) |
| dst_word | input | 1 | Destination is word-wide RAM (1) or byte-wide main RAM (0), sampled at start |
| dma_start | input | 1 | Start a transfer |
| dma_len | input | 16 | Transfer length in words |
| src_data | input | 16 | Host word, captured when src_rd is high |
| refresh_stb | output | 1 | This slot is a refresh slot |
| src_rd | output | 1 | Source read performed in this slot |
| mem_wr | output | 1 | Destination write granted in this slot |
| wr_hi | output | 1 | Byte destination: high byte phase of the write |
| wr_data | output | 16 | Word at the head of the queue |
| bus_held | output | 1 | Host bus held by the transfer |

## Verification
The bench records, slot by slot, where refresh lands in all four mode combinations. A decoder with a shifted or missing entry shows up as a wrong slot or a wrong count. It counts source reads across a whole line for both destination types. A design that drops only one read per refresh, or stalls the slot after a refresh for writes as well as reads, misses the 198/204 figures. A single-word transfer pins the queue latency to exactly three slots, so an early or late write is caught. A second start issued mid-transfer and a zero-length start show whether the length register is reloaded when it must not be.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  // Line mode as seen by the refresh decoder.
  typedef enum logic [1:0] {
    MODE_NARROW_ON  = 2'b00,
    MODE_NARROW_OFF = 2'b01,
    MODE_WIDE_ON    = 2'b10,
    MODE_WIDE_OFF   = 2'b11
  } line_mode_e;

  function automatic line_mode_e mode_of(input logic wide, input logic disp);
    return line_mode_e'({wide, ~disp});
  endfunction

  // Refresh position decode: one case per line mode.
  function automatic logic rfsh_hit(input int idx, input line_mode_e m);
    logic hit;
    hit = 1'b0;
    case (m)
      MODE_WIDE_OFF:   hit = (idx == 37) || (idx == 69) || (idx == 102) ||
                             (idx == 133) || (idx == 165) || (idx == 197);
      MODE_WIDE_ON:    hit = (idx == 26) || (idx == 58) || (idx == 90) ||
                             (idx == 122) || (idx == 154);
      MODE_NARROW_OFF: hit = (idx == 37) || (idx == 69) || (idx == 101) ||
                             (idx == 133) || (idx == 165);
      MODE_NARROW_ON:  hit = (idx == 26) || (idx == 58) || (idx == 90) ||
                             (idx == 122);
      default:         hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Ring pointer advance for a queue of arbitrary depth.
  function automatic int ptr_step(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Queue occupancy after one slot.
  function automatic int occ_next(input int occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/slot_rfsh_gen.sv
module slot_rfsh_gen
  import slot_sched_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              disp_on,
  input  logic              wide_mode,
  output logic              refresh_stb,
  output logic              post_rfsh
);

  line_mode_e mode;
  logic       hit;

  always_comb begin
    mode        = mode_of(wide_mode, disp_on);
    hit         = rfsh_hit(int'(slot_idx), mode);
    refresh_stb = slot_en && hit;
  end

  // Marks the slot after a refresh, whose source read is also lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_rfsh <= 1'b0;
    end else if (slot_en) begin
      post_rfsh <= refresh_stb;
    end
  end

endmodule

// File: rtl/slot_len_ctr.sv
module slot_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             dst_word_in,
  input  logic             rd,
  output logic [LEN_W-1:0] len_left,
  output logic             dst_word_q,
  output logic             held
);

  assign held = (len_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_left   <= '0;
      dst_word_q <= 1'b1;
    end else if (start && !held) begin
      len_left   <= len_in;
      dst_word_q <= dst_word_in;
    end else if (rd && held) begin
      len_left   <= len_left - 1'b1;
    end
  end

endmodule

// File: rtl/slot_wqueue.sv
module slot_wqueue
  import slot_sched_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LAT    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slot_en,
  input  logic                        blocked,
  input  logic                        dst_word,
  input  logic                        push,
  input  logic [DATA_W-1:0]           push_data,
  output logic                        wr,
  output logic                        wr_hi,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        pop,
  output logic [$clog2(DEPTH+1)-1:0]  occ,
  output logic                        has_room
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AGE_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [AGE_W-1:0]  age   [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              half_q;
  logic              head_ready;

  assign has_room   = (occ < CNT_W'(DEPTH));
  assign head_ready = (occ != '0) && (age[rp] >= AGE_W'(LAT));
  assign wr         = slot_en && !blocked && head_ready;
  assign wr_hi      = !dst_word && !half_q;
  assign wr_data    = store[rp];
  assign pop        = wr && (dst_word || half_q);

  // Per-entry age counters: set on entry, saturate at the latency.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age[i] <= '0;
      end else if (push && (wp == PTR_W'(i))) begin
        age[i] <= AGE_W'(1);
      end else if (slot_en && (age[i] != '0) && (age[i] < AGE_W'(LAT))) begin
        age[i] <= age[i] + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push && (wp == PTR_W'(i))) begin
        store[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      occ    <= '0;
      half_q <= 1'b0;
    end else begin
      if (push) wp <= PTR_W'(ptr_step(int'(wp), DEPTH));
      if (pop)  rp <= PTR_W'(ptr_step(int'(rp), DEPTH));
      occ <= CNT_W'(occ_next(int'(occ), push, pop));
      if (wr && !dst_word) half_q <= !half_q;
    end
  end

endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              disp_on,
  input  logic              wide_mode,
  input  logic              dst_word,
  input  logic              dma_start,
  input  logic [LEN_W-1:0]  dma_len,
  input  logic [DATA_W-1:0] src_data,
  output logic              refresh_stb,
  output logic              src_rd,
  output logic              mem_wr,
  output logic              wr_hi,
  output logic [DATA_W-1:0] wr_data,
  output logic              bus_held
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // Named internal events, used by the bound checker.
  logic             post_rfsh;
  logic             dst_word_q;
  logic [LEN_W-1:0] len_left;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_room;
  logic             fifo_pop;
  logic             rd_blocked;

  slot_rfsh_gen #(.SLOT_W(SLOT_W)) u_rfsh (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_en     (slot_en),
    .slot_idx    (slot_idx),
    .disp_on     (disp_on),
    .wide_mode   (wide_mode),
    .refresh_stb (refresh_stb),
    .post_rfsh   (post_rfsh)
  );

  slot_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (dma_start),
    .len_in      (dma_len),
    .dst_word_in (dst_word),
    .rd          (src_rd),
    .len_left    (len_left),
    .dst_word_q  (dst_word_q),
    .held        (bus_held)
  );

  // A refresh costs its own read slot and the following one.
  assign rd_blocked = refresh_stb || post_rfsh;
  assign src_rd     = slot_en && bus_held && !rd_blocked && fifo_room;

  slot_wqueue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .blocked   (refresh_stb),
    .dst_word  (dst_word_q),
    .push      (src_rd),
    .push_data (src_data),
    .wr        (mem_wr),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .pop       (fifo_pop),
    .occ       (fifo_cnt),
    .has_room  (fifo_room)
  );

endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int LEN_W = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_en,
  input logic             refresh_stb,
  input logic             src_rd,
  input logic             mem_wr,
  input logic             bus_held,
  input logic             post_rfsh,
  input logic [LEN_W-1:0] len_left,
  input logic [CNT_W-1:0] fifo_cnt
);

  // R4
  rfsh_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_stb |-> (!src_rd && !mem_wr));

  // R4
  lost_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_rfsh && slot_en) |-> !src_rd);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  // R8
  wr_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (fifo_cnt != '0));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_held |-> !src_rd);

  // R10
  len_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> (len_left == $past(len_left) - 1'b1));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |-> !(refresh_stb || src_rd || mem_wr));

endmodule

bind slot_sched slot_sched_chk #(.LEN_W(LEN_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_en     (slot_en),
  .refresh_stb (refresh_stb),
  .src_rd      (src_rd),
  .mem_wr      (mem_wr),
  .bus_held    (bus_held),
  .post_rfsh   (post_rfsh),
  .len_left    (len_left),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/slot_sched_test.sv
module slot_sched_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_en, disp_on, wide_mode, dst_word, dma_start;
  logic [7:0]  slot_idx;
  logic [15:0] dma_len, src_data;
  logic        refresh_stb, src_rd, mem_wr, wr_hi, bus_held;
  logic [15:0] wr_data;

  always #4 clk = ~clk;

  slot_sched uut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_idx(slot_idx),
    .disp_on(disp_on), .wide_mode(wide_mode), .dst_word(dst_word),
    .dma_start(dma_start), .dma_len(dma_len), .src_data(src_data),
    .refresh_stb(refresh_stb), .src_rd(src_rd), .mem_wr(mem_wr),
    .wr_hi(wr_hi), .wr_data(wr_data), .bus_held(bus_held)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side state
  int rd_idx, wr_idx, abs_slot, max_out, byte_phase;
  bit exp_byte;
  int rd_slot [0:1023];
  bit rf_a [0:255];
  bit rd_a [0:255];
  bit wr_a [0:255];
  int n_rd, n_wr, n_rf, rd_bad, wr_bad, data_err, lat_err, hi_err;
  int first_wr_slot;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int n);
    return 16'(n * 37 + 4660);
  endfunction

  function automatic bit exp_rf(input int s, input bit wide, input bit disp);
    int wo[6] = '{37, 69, 102, 133, 165, 197};
    int wn[5] = '{26, 58, 90, 122, 154};
    int no[5] = '{37, 69, 101, 133, 165};
    int nn[4] = '{26, 58, 90, 122};
    bit r = 0;
    if (wide && !disp) foreach (wo[i]) r |= (wo[i] == s);
    if (wide && disp)  foreach (wn[i]) r |= (wn[i] == s);
    if (!wide && !disp) foreach (no[i]) r |= (no[i] == s);
    if (!wide && disp) foreach (nn[i]) r |= (nn[i] == s);
    return r;
  endfunction

  task automatic apply_reset();
    rst_n = 0; slot_en = 0; slot_idx = 0; disp_on = 0; wide_mode = 1;
    dst_word = 1; dma_start = 0; dma_len = 0; src_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_idx = 0; wr_idx = 0; abs_slot = 0; max_out = 0; byte_phase = 0;
  endtask

  task automatic start_dma(input int len, input bit word);
    @(negedge clk);
    slot_en = 0; dma_start = 1; dma_len = 16'(len); dst_word = word; exp_byte = !word;
    @(negedge clk);
    dma_start = 0;
  endtask

  task automatic run_line(input int n, input bit wide, input bit disp);
    bit prev_rf = 0;
    n_rd = 0; n_wr = 0; n_rf = 0; rd_bad = 0; wr_bad = 0;
    data_err = 0; lat_err = 0; hi_err = 0; first_wr_slot = -1;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      slot_en = 1; slot_idx = 8'(s); wide_mode = wide; disp_on = disp;
      src_data = pat(rd_idx);
      #2;
      rf_a[s] = refresh_stb; rd_a[s] = src_rd; wr_a[s] = mem_wr;
      if (refresh_stb) n_rf++;
      if (src_rd) begin
        n_rd++;
        if (refresh_stb || prev_rf) rd_bad++;
        if (rd_idx < 1024) rd_slot[rd_idx] = abs_slot;
        rd_idx++;
      end
      if (mem_wr) begin
        n_wr++;
        if (first_wr_slot < 0) first_wr_slot = s;
        if (refresh_stb) wr_bad++;
        if (wr_data != pat(wr_idx)) data_err++;
        if (wr_idx < 1024 && abs_slot < rd_slot[wr_idx] + 3) lat_err++;
        if (exp_byte) begin
          if (wr_hi != (byte_phase == 0)) hi_err++;
          if (byte_phase == 1) wr_idx++;
          byte_phase ^= 1;
        end else begin
          if (wr_hi) hi_err++;
          wr_idx++;
        end
      end
      if (rd_idx - wr_idx > max_out) max_out = rd_idx - wr_idx;
      prev_rf = refresh_stb;
      abs_slot++;
    end
    @(negedge clk);
    slot_en = 0;
  endtask

  task automatic t_reset();
    apply_reset();
    #2;
    chk(!refresh_stb && !src_rd && !mem_wr && !bus_held, "R11", "outputs after reset",
        {refresh_stb, src_rd, mem_wr, bus_held}, 0);
  endtask

  task automatic t_refresh_map();
    for (int m = 0; m < 4; m++) begin
      bit wide = m[1];
      bit disp = m[0];
      int n = wide ? 210 : 171;
      int mism = 0;
      int exp_cnt = 0;
      string req = wide ? (disp ? "R3" : "R1") : "R2";
      apply_reset();
      run_line(n, wide, disp);
      for (int s = 0; s < n; s++) begin
        if (exp_rf(s, wide, disp)) exp_cnt++;
        if (rf_a[s] != exp_rf(s, wide, disp)) mism++;
      end
      chk(mism == 0, req, "refresh slot mismatches", mism, 0);
      chk(n_rf == exp_cnt, req, "refresh count per line", n_rf, exp_cnt);
    end
    // R11: no strobe while slot_en low
    #2;
    chk(!refresh_stb && !src_rd && !mem_wr, "R11", "quiet when slot_en low",
        {refresh_stb, src_rd, mem_wr}, 0);
  endtask

  task automatic t_word_line();
    apply_reset();
    start_dma(1000, 1'b1);
    run_line(210, 1'b1, 1'b0);
    chk(n_rd == 198, "R6", "word reads in wide blank line", n_rd, 198);
    chk(rd_bad == 0, "R4", "reads in refresh or following slot", rd_bad, 0);
    chk(wr_bad == 0, "R4", "writes in refresh slot", wr_bad, 0);
    chk(data_err == 0 && hi_err == 0, "R6", "word data/order errors", data_err + hi_err, 0);
    chk(wr_a[38] == 1, "R4", "write allowed in slot after refresh", wr_a[38], 1);
    chk(rd_a[36] == 1, "R5", "read in unblocked slot", rd_a[36], 1);
    chk(lat_err == 0, "R8", "writes earlier than latency", lat_err, 0);
    // narrow, display on
    apply_reset();
    start_dma(1000, 1'b1);
    run_line(171, 1'b0, 1'b1);
    chk(n_rd == 163, "R6", "word reads in narrow live line", n_rd, 163);
    chk(rd_bad == 0 && wr_bad == 0, "R4", "refresh blocking narrow", rd_bad + wr_bad, 0);
  endtask

  task automatic t_latency();
    apply_reset();
    start_dma(1, 1'b1);
    #2;
    chk(bus_held == 1, "R10", "bus held after start", bus_held, 1);
    run_line(210, 1'b1, 1'b0);
    chk(n_rd == 1 && rd_a[0] == 1, "R5", "single read at slot 0", n_rd, 1);
    chk(first_wr_slot == 3, "R8", "single word write slot", first_wr_slot, 3);
    chk(n_wr == 1 && data_err == 0, "R8", "single word written once", n_wr, 1);
    #2;
    chk(bus_held == 0, "R10", "bus released at zero", bus_held, 0);
  endtask

  task automatic t_byte_steady();
    apply_reset();
    start_dma(2000, 1'b0);
    dst_word = 1;  // changed after start: must not matter (R10)
    run_line(210, 1'b1, 1'b0);
    run_line(210, 1'b1, 1'b0);
    chk(n_wr == 204, "R7", "byte writes in steady wide blank line", n_wr, 204);
    chk(hi_err == 0, "R7", "high byte first ordering", hi_err, 0);
    chk(data_err == 0, "R9", "write data order", data_err, 0);
    chk(max_out == 4, "R9", "max queued words", max_out, 4);
    chk(rd_bad == 0 && wr_bad == 0, "R4", "refresh blocking byte mode", rd_bad + wr_bad, 0);
    chk(lat_err == 0, "R8", "byte mode latency", lat_err, 0);
  endtask

  task automatic t_length();
    int total;
    apply_reset();
    start_dma(5, 1'b1);
    run_line(3, 1'b1, 1'b0);
    total = n_rd;
    start_dma(9, 1'b1);  // ignored while held (R10)
    run_line(210, 1'b1, 1'b0);
    total += n_rd;
    chk(total == 5, "R10", "reads equal programmed length", total, 5);
    #2;
    chk(bus_held == 0, "R10", "released after length", bus_held, 0);
    chk(data_err == 0, "R9", "length test data", data_err, 0);
    apply_reset();
    start_dma(0, 1'b1);
    #2;
    chk(bus_held == 0, "R10", "zero length start", bus_held, 0);
    run_line(20, 1'b1, 1'b0);
    chk(n_rd == 0 && n_wr == 0, "R10", "zero length no traffic", n_rd + n_wr, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    t_reset();
    t_refresh_map();
    t_word_line();
    t_latency();
    t_byte_steady();
    t_length();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule